// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block is a small, fully associative store of recent virtual-to-physical page translations. A 32-bit virtual address splits into a 16-bit virtual page number (bits 31:16) and a 16-bit page offset. A hit returns a 28-bit physical address made of a 12-bit physical page number with the untranslated offset appended. Each entry is tagged with both the page number and a process identifier. Because of this, entries from different address spaces can live side by side and a context switch does not have to empty the buffer.

A lookup is resolved in the same cycle it is presented, against the contents registered at the previous clock edge. The result is a hit or a miss, plus a permission fault when the entry forbids the requested access type. After a miss, the page-table walker outside this block supplies the missing translation through the fill port. A fill takes, in order of preference: the entry that already holds the same page and process, then the lowest-numbered empty entry, then the entry named by a round-robin pointer. A flush command can invalidate every entry, or only the entries of one process. Both kinds of flush complete in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After a synchronous active-low reset every entry is invalid, so any lookup reports a miss.
- R2: A fill accepted at a clock edge is visible to a lookup in the next cycle. That lookup hits and returns the filled page number.
- R3: With `lk_valid` high, `lk_hit` and `lk_miss` are combinational outputs of the current request. A miss is reported when no valid entry matches both the page number and the process identifier. With `lk_valid` low, `lk_hit`, `lk_miss`, `lk_fault` and `lk_paddr` are all zero.
- R4: On a hit, `lk_paddr` is the entry's 12-bit physical page number in bits 27:16 followed by `lk_vaddr[15:0]`. On a miss, `lk_paddr` is zero.
- R5: Permission bits are coded as bit 0 read, bit 1 write and bit 2 execute. Access codes are 0 read, 1 write, 2 execute and 3 reserved. `lk_fault` is raised only on a hit, when the permission bit for the access code is clear; the reserved code always faults. `lk_hit` stays high when a fault is raised.
- R6: A fill whose page number and process identifier match no valid entry is written into the lowest-numbered invalid entry, if any entry is invalid.
- R7: When all entries are valid and the fill matches none of them, the fill replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset, advances by one after each such replacement and wraps after the last entry.
- R8: A per-process flush invalidates, in one cycle, exactly the entries whose process identifier equals `flush_asid`. All other entries keep working.
- R9: A global flush invalidates every entry in one cycle.
- R10: When a flush and a fill are presented in the same cycle, the flush is performed and the fill is dropped.
- R11: A fill that matches a valid entry on both page number and process identifier overwrites that entry, so at most one entry ever matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Process identifier of the request |
| lk_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | No translation found |
| lk_fault | output | 1 | Hit whose permissions forbid the access |
| lk_paddr | output | 28 | Translated physical address |
| fill_valid | input | 1 | Write a translation |
| fill_vpn | input | 16 | Virtual page number of the fill |
| fill_asid | input | 8 | Process identifier of the fill |
| fill_ppn | input | 12 | Physical page number of the fill |
| fill_perm | input | 3 | Permissions of the fill: bit 0 read, bit 1 write, bit 2 execute |
| flush_valid | input | 1 | Flush command |
| flush_global | input | 1 | 1: flush all entries, 0: flush only `flush_asid` |
| flush_asid | input | 8 | Process identifier for a per-process flush |

## Verification
The lookup outputs are due in the same cycle as the request, with no register on their path. A fill or flush changes what lookups see from the cycle after the clock edge that takes it. The bench therefore drives every input on the falling edge and compares the lookup outputs with its reference model one nanosecond later. Only after that does it commit the cycle's fill or flush into the model, at the rising edge. Replacement order is observed at the ports by probing every page the model holds after each sequence of fills and flushes.

// File: rtl/tlb_pkg.sv
// Package: address geometry and entry layout shared by the translation buffer.
// Assumes 64 KB pages, 32-bit virtual and 28-bit physical addresses.
package tlb_pkg;
    parameter int VA_W   = 32;
    parameter int OFS_W  = 16;
    parameter int PA_W   = 28;
    parameter int ASID_W = 8;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        perm_t             perm;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
// Module: parallel tag compare across all entries.
// Produces one match bit per entry: valid, page number and process id all equal.
// Assumes the caller keeps at most one entry per (page, process) pair.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_entry_t [ENTRIES-1:0] ent_i,
    input  logic [ENTRIES-1:0]       valid_i,
    input  logic [VPN_W-1:0]         vpn_i,
    input  logic [ASID_W-1:0]        asid_i,
    output logic [ENTRIES-1:0]       match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // per-entry comparator
        assign match_o[g] = valid_i[g] && (ent_i[g].vpn == vpn_i) && (ent_i[g].asid == asid_i);
    end
endmodule

// File: rtl/tlb_victim.sv
// Module: chooses the entry a fill writes.
// Priority: duplicate entry, then lowest invalid entry, then round-robin pointer.
// The pointer moves only when a fill actually replaces a valid, unrelated entry.
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] dup_i,
    output logic [IDX_W-1:0]   idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             has_dup;
    logic             has_free;

    // encode the duplicate and the lowest free slot
    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        has_dup  = |dup_i;
        has_free = ~&valid_i;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
            if (dup_i[i])    dup_idx  = IDX_W'(i);
        end
    end

    // pick the write slot by priority
    always_comb begin
        if (has_dup)       idx_o = dup_idx;
        else if (has_free) idx_o = free_idx;
        else               idx_o = rr_q;
    end

    // advance the round-robin pointer on each replacement
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fill_go && !has_dup && !has_free)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/tlb_xlate.sv
// Module: fully associative, process-tagged translation buffer (top).
// Lookups resolve combinationally against the registered entries; fills and
// flushes update the entries at the clock edge, with flush taking precedence.
// Assumes the external walker fills only after a miss and holds inputs stable
// around the rising edge.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [ASID_W-1:0]   lk_asid,
    input  logic [1:0]          lk_acc,
    output logic                lk_hit,
    output logic                lk_miss,
    output logic                lk_fault,
    output logic [PA_W-1:0]     lk_paddr,
    input  logic                fill_valid,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [ASID_W-1:0]   fill_asid,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [2:0]          fill_perm,
    input  logic                flush_valid,
    input  logic                flush_global,
    input  logic [ASID_W-1:0]   flush_asid
);
    localparam int IDX_W = $clog2(ENTRIES);

    tlb_entry_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]       valid_q;
    logic [ENTRIES-1:0]       lk_match;
    logic [ENTRIES-1:0]       fill_dup;
    logic [ENTRIES-1:0]       flush_hit;
    logic [IDX_W-1:0]         wr_idx;
    logic                     fill_go;
    logic [PPN_W-1:0]         sel_ppn;
    perm_t                    sel_perm;
    logic                     any_hit;
    logic                     allowed;

    assign fill_go = fill_valid && !flush_valid;

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ent_i   (ent_q),
        .valid_i (valid_q),
        .vpn_i   (lk_vaddr[VA_W-1:OFS_W]),
        .asid_i  (lk_asid),
        .match_o (lk_match)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_fill_match (
        .ent_i   (ent_q),
        .valid_i (valid_q),
        .vpn_i   (fill_vpn),
        .asid_i  (fill_asid),
        .match_o (fill_dup)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill_go (fill_go),
        .valid_i (valid_q),
        .dup_i   (fill_dup),
        .idx_o   (wr_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flush
        // per-entry process-id compare for selective flush
        assign flush_hit[g] = flush_global || (ent_q[g].asid == flush_asid);
    end

    // OR-mux the matching entry's data
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_ppn  = sel_ppn  | (ent_q[i].ppn & {PPN_W{lk_match[i]}});
            sel_perm = sel_perm | (ent_q[i].perm & {3{lk_match[i]}});
        end
        any_hit = |lk_match;
    end

    // permission check for the requested access type
    always_comb begin
        case (acc_e'(lk_acc))
            ACC_READ:  allowed = sel_perm.r;
            ACC_WRITE: allowed = sel_perm.w;
            ACC_EXEC:  allowed = sel_perm.x;
            default:   allowed = 1'b0;
        endcase
    end

    // drive lookup results
    always_comb begin
        lk_hit   = lk_valid && any_hit;
        lk_miss  = lk_valid && !any_hit;
        lk_fault = lk_hit && !allowed;
        lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFS_W-1:0]} : '0;
    end

    // entry state update: flush first, otherwise fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ent_q   <= '0;
        end else if (flush_valid) begin
            valid_q <= valid_q & ~flush_hit;
        end else if (fill_valid) begin
            valid_q[wr_idx] <= 1'b1;
            ent_q[wr_idx]   <= '{vpn: fill_vpn, asid: fill_asid, ppn: fill_ppn, perm: perm_t'(fill_perm)};
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
// Module: property checker for the translation buffer, bound to the top.
// Observes ports plus the valid and match vectors built by separate logic.
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic [ASID_W-1:0]  lk_asid,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               fill_valid,
    input logic [VPN_W-1:0]   fill_vpn,
    input logic [ASID_W-1:0]  fill_asid,
    input logic [PPN_W-1:0]   fill_ppn,
    input logic               flush_valid,
    input logic               flush_global,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] lk_match
);
    p_fill_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !flush_valid |=>
            (!(lk_valid && lk_vaddr[VA_W-1:OFS_W] == $past(fill_vpn) && lk_asid == $past(fill_asid))
             || (lk_hit && lk_paddr[PA_W-1:OFS_W] == $past(fill_ppn))));

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]);

    p_fault_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    p_global_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid && flush_global |=> valid_q == '0);

    p_single_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .lk_asid      (lk_asid),
    .lk_hit       (lk_hit),
    .lk_fault     (lk_fault),
    .lk_paddr     (lk_paddr),
    .fill_valid   (fill_valid),
    .fill_vpn     (fill_vpn),
    .fill_asid    (fill_asid),
    .fill_ppn     (fill_ppn),
    .flush_valid  (flush_valid),
    .flush_global (flush_global),
    .valid_q      (valid_q),
    .lk_match     (lk_match)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the lookup port every cycle.
module tlb_xlate_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [27:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [11:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_valid = 1'b0;
    logic        flush_global = 1'b0;
    logic [7:0]  flush_asid = '0;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit          m_v    [N];
    logic [15:0] m_vpn  [N];
    logic [7:0]  m_asid [N];
    logic [11:0] m_ppn  [N];
    logic [2:0]  m_perm [N];
    int          m_rr;
    logic [15:0] keys_vpn  [$];
    logic [7:0]  keys_asid [$];

    always #2.5 clk = ~clk;

    tlb_xlate #(.ENTRIES(N)) u_tlb_xlate (.*);

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // compare outputs with the model, then commit the cycle at the rising edge
    task automatic cycle(input string tag);
        logic e_hit, e_miss, e_fault;
        logic [27:0] e_pa;
        int dup, slot;
        #1;
        e_hit = 0; e_miss = 0; e_fault = 0; e_pa = '0;
        if (lk_valid) begin
            e_miss = 1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == lk_vaddr[31:16] && m_asid[i] == lk_asid) begin
                    e_hit = 1; e_miss = 0;
                    e_pa = {m_ppn[i], lk_vaddr[15:0]};
                    e_fault = (lk_acc == 2'd3) ? 1'b1 : !m_perm[i][lk_acc];
                end
        end
        if (rst_n) begin
            checks++;
            if ({lk_hit, lk_miss, lk_fault, lk_paddr} !== {e_hit, e_miss, e_fault, e_pa}) begin
                fails++;
                $display("FAIL %s: actual hit=%0b miss=%0b fault=%0b pa=%h expected hit=%0b miss=%0b fault=%0b pa=%h",
                         tag, lk_hit, lk_miss, lk_fault, lk_paddr, e_hit, e_miss, e_fault, e_pa);
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_rr = 0;
        end else if (flush_valid) begin
            for (int i = 0; i < N; i++)
                if (flush_global || m_asid[i] == flush_asid) m_v[i] = 0;
        end else if (fill_valid) begin
            dup = -1; slot = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == fill_vpn && m_asid[i] == fill_asid) dup = i;
            for (int i = N - 1; i >= 0; i--)
                if (!m_v[i]) slot = i;
            if (dup >= 0) slot = dup;
            else if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
            m_v[slot] = 1; m_vpn[slot] = fill_vpn; m_asid[slot] = fill_asid;
            m_ppn[slot] = fill_ppn; m_perm[slot] = fill_perm;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        lk_valid = 0; fill_valid = 0; flush_valid = 0; flush_global = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] acc, input string tag);
        quiet();
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_acc = acc;
        cycle(tag);
    endtask

    task automatic fill(input logic [15:0] vpn, input logic [7:0] asid, input logic [11:0] ppn,
                        input logic [2:0] perm, input string tag);
        quiet();
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn; fill_perm = perm;
        keys_vpn.push_back(vpn); keys_asid.push_back(asid);
        cycle(tag);
    endtask

    task automatic flush(input logic glob, input logic [7:0] asid, input string tag);
        quiet();
        flush_valid = 1; flush_global = glob; flush_asid = asid;
        cycle(tag);
    endtask

    // look up every page ever filled, with an unrelated offset
    task automatic probe_all(input string tag);
        for (int k = 0; k < keys_vpn.size(); k++)
            look({keys_vpn[k], 16'h5A3C}, keys_asid[k], 2'd0, tag);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) cycle("reset");
        rst_n = 1;
        look(32'h1234_5678, 8'd1, 2'd0, "R1");
        look(32'h0000_0000, 8'd0, 2'd0, "R1");
        fill(16'h1234, 8'd1, 12'hABC, 3'b001, "R2");
        look(32'h1234_5678, 8'd1, 2'd0, "R2");
        look(32'h1234_FFFF, 8'd1, 2'd0, "R4");
        look(32'h1234_0001, 8'd1, 2'd1, "R5");
        look(32'h1234_0002, 8'd1, 2'd2, "R5");
        look(32'h1234_0003, 8'd1, 2'd3, "R5");
        look(32'h1234_0000, 8'd2, 2'd0, "R3");
        look(32'h1235_0000, 8'd1, 2'd0, "R3");
        quiet(); lk_vaddr = 32'h1234_5678; lk_asid = 8'd1; cycle("R3");
        fill(16'h1234, 8'd1, 12'h555, 3'b110, "R11");
        look(32'h1234_0010, 8'd1, 2'd0, "R11");
        look(32'h1234_0010, 8'd1, 2'd1, "R11");
        look(32'h1234_0010, 8'd1, 2'd2, "R11");
        for (int i = 0; i < N - 1; i++)
            fill(16'h2000 + 16'(i), 8'd2, 12'(i + 1), 3'b111, "R6");
        probe_all("R6");
        for (int i = 0; i < 5; i++)
            fill(16'h3000 + 16'(i), 8'd3, 12'h300 + 12'(i), 3'b011, "R7");
        probe_all("R7");
        flush(1'b0, 8'd2, "R8");
        probe_all("R8");
        fill(16'h4000, 8'd5, 12'h400, 3'b100, "R6");
        fill(16'h4001, 8'd5, 12'h401, 3'b100, "R6");
        probe_all("R6");
        look(32'h4000_1111, 8'd5, 2'd2, "R5");
        quiet();
        flush_valid = 1; flush_global = 0; flush_asid = 8'd5;
        fill_valid = 1; fill_vpn = 16'h5000; fill_asid = 8'd7; fill_ppn = 12'h500; fill_perm = 3'b001;
        keys_vpn.push_back(16'h5000); keys_asid.push_back(8'd7);
        cycle("R10");
        probe_all("R10");
        flush(1'b1, 8'd0, "R9");
        probe_all("R9");
        for (int i = 0; i < N + 7; i++)
            fill(16'h6000 + 16'(i), 8'(i % 3), 12'h600 + 12'(i), 3'(i % 8), "R7");
        probe_all("R7");
        fill(16'h6003, 8'd0, 12'hFFF, 3'b111, "R11");
        probe_all("R11");
        quiet();
        cycle("R3");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule